// File: doc/BRIEF.md
# Triggered Multichannel DAC Scan FIFO

This block holds sample words for a bank of up to sixteen DAC channels in a 4096-entry FIFO. Each conversion trigger moves one scan out of the FIFO. A scan is one word for every channel enabled in the channel mask, taken in ascending channel order. Each word lands in that channel's output register, and the register feeds the converter. Software loads samples through a data port. It picks where triggers come from, sets a polarity bit and a reference-select field that go to the analog side, and reads back a coarse fill code and a busy flag.

The trigger can be held off, issued by software, taken from either edge of an external pin, or taken from the rising edge of one of three counter outputs. A level interrupt follows one of six FIFO conditions. When wrap mode is on, each word that leaves the FIFO is written back to its tail, so a loaded waveform plays in a loop with no further host writes.

Top module: `dac_scan_fifo`

## Requirements
- R1: After reset, the control/status word (address 1) reads 0x1000, the mask (address 2) reads 0, every channel output is 0, irq is 0, polarity_bip is 0 and vref_sel is 0.
- R2: Writing address 1 stores the configuration bits 11:0, which read back in the same positions: trigger source in 2:0, bipolar in 3, reference select in 5:4, wrap in 7, FIFO enable in 8 and interrupt condition in 11:9. Bit 6 always reads 0. polarity_bip follows bit 3 and vref_sel follows bits 5:4.
- R3: Status bits 14:12 hold the fill code: 1 when the FIFO is empty, 0 for 1 to DEPTH/2-1 words, 4 for DEPTH/2 to DEPTH-1 words, and 6 when the FIFO is full.
- R4: irq is high only while the FIFO is enabled and the selected condition holds. The conditions are 0 empty, 1 not empty, 2 below half, 3 half or more, 4 not full and 5 full. Codes 6 and 7 never raise irq.
- R5: A write to address 0 appends the word only when the FIFO is enabled, is not full and no scan is in progress. Otherwise the word is dropped.
- R6: The trigger source codes are 1, a read of address 0; 2, a rising edge on ext_trig; 3, a falling edge on ext_trig; and 4, 5, 6, a rising edge on ctr_tick bit 0, 1 or 2. Codes 0 and 7 never trigger.
- R7: An accepted trigger pops one word per enabled channel, lowest channel first. Each channel output takes the upper DAC_BITS bits of its word. Status bit 15 (busy) is high from the cycle after the trigger until the scan completes.
- R8: A trigger is ignored, and moves no word, when the FIFO holds fewer words than there are enabled channels, when the mask is zero, when the FIFO is disabled, or when a scan is already in progress.
- R9: With wrap set, each popped word is appended back to the FIFO. The fill level is unchanged by a scan, and the waveform repeats.
- R10: A control write with bit 12 set empties the FIFO and aborts any scan, while bits 11:0 of the same write are stored. Bit 12 is not stored.
- R11: A control write with bit 13 set returns configuration, mask, FIFO and channel outputs to the reset state. The other bits of that write are ignored.
- R12: Address 2 writes and reads the channel mask in bits NCH-1:0. A read of address 0 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address: 0 data, 1 control/status, 2 mask |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| ext_trig | input | 1 | External trigger pin |
| ctr_tick | input | NCTR | Counter outputs used as triggers |
| irq | output | 1 | Level interrupt |
| polarity_bip | output | 1 | Bipolar output range selected |
| vref_sel | output | 2 | Reference voltage select |
| dac_out | output | NCH*DAC_BITS | Channel output registers, channel 0 in the low bits |

## Verification
A wrong fill count shows at once in the status fill code and in irq on the next status read, but only once the count crosses the empty, half or full boundary. A read or write pointer that is off shows as a wrong word on some channel output, and it shows within NCH+1 cycles of the next accepted trigger. A fault in wrap recycling stays hidden on the first pass through the data and appears only when recycled words come round again. The bench therefore runs long random sequences that loop the same words many times.

// File: rtl/dsf_pkg.sv
package dsf_pkg;

   // trigger source codes, stored in control bits 2:0
   typedef enum logic [2:0] {
      TRG_HOLD     = 3'd0,
      TRG_SOFT     = 3'd1,
      TRG_EXT_RISE = 3'd2,
      TRG_EXT_FALL = 3'd3,
      TRG_CTR0     = 3'd4,
      TRG_CTR1     = 3'd5,
      TRG_CTR2     = 3'd6,
      TRG_SPARE    = 3'd7
   } trig_sel_e;

   // interrupt condition codes, stored in control bits 11:9
   typedef enum logic [2:0] {
      IRQ_EMPTY     = 3'd0,
      IRQ_NOT_EMPTY = 3'd1,
      IRQ_LOW_HALF  = 3'd2,
      IRQ_HIGH_HALF = 3'd3,
      IRQ_NOT_FULL  = 3'd4,
      IRQ_FULL      = 3'd5,
      IRQ_SPARE6    = 3'd6,
      IRQ_SPARE7    = 3'd7
   } irq_sel_e;

   // stored configuration, laid out to match the register bit positions
   typedef struct packed {
      irq_sel_e   irq_sel;   // 11:9
      logic       fifo_en;   // 8
      logic       wrap;      // 7
      logic       spare;     // 6, always zero
      logic [1:0] vref;      // 5:4
      logic       bipolar;   // 3
      trig_sel_e  trig;      // 2:0
   } cfg_t;

   localparam logic [1:0] ADDR_DATA = 2'd0;
   localparam logic [1:0] ADDR_CTRL = 2'd1;
   localparam logic [1:0] ADDR_MASK = 2'd2;

   localparam int BIT_FIFO_CLR = 12;
   localparam int BIT_ALL_CLR  = 13;

   localparam logic [2:0] FILL_EMPTY = 3'd1;
   localparam logic [2:0] FILL_LOW   = 3'd0;
   localparam logic [2:0] FILL_HIGH  = 3'd4;
   localparam logic [2:0] FILL_FULL  = 3'd6;

endpackage

// File: rtl/dsf_fifo.sv
module dsf_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 4096,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic [W-1:0]  push_data,
   input  logic          pop,
   input  logic          recycle,
   output logic [W-1:0]  head,
   output logic [CW-1:0] level
);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] cnt;
   logic          full, do_wr, do_rd;
   logic [W-1:0]  wdat;

   assign full  = (cnt == CW'(DEPTH));
   assign do_rd = ~clr & pop;
   // a recycled word and a host word never meet: the host is held off during a scan
   assign do_wr = ~clr & ((pop & recycle) | (push & ~pop & ~full));
   assign wdat  = pop ? head : push_data;
   assign head  = mem[rd_ptr];
   assign level = cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_wr) wr_ptr <= wr_ptr + AW'(1);
         if (do_rd) rd_ptr <= rd_ptr + AW'(1);
         cnt <= cnt + CW'(do_wr) - CW'(do_rd);
      end
   end

   always_ff @(posedge clk) begin
      if (do_wr) mem[wr_ptr] <= wdat;
   end

endmodule

// File: rtl/dsf_trig.sv
module dsf_trig
   import dsf_pkg::*;
#(
   parameter int NCTR = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  trig_sel_e       src,
   input  logic            sw_req,
   input  logic            ext_in,
   input  logic [NCTR-1:0] ctr_in,
   output logic            fire
);

   logic            ext_q;
   logic [NCTR-1:0] ctr_q;
   logic [2:0]      ctr_rise;
   logic            ext_rise, ext_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_q <= 1'b0;
         ctr_q <= '0;
      end else begin
         ext_q <= ext_in;
         ctr_q <= ctr_in;
      end
   end

   assign ext_rise = ext_in & ~ext_q;
   assign ext_fall = ~ext_in & ext_q;

   // counters beyond NCTR are tied off so their select codes never fire
   for (genvar g = 0; g < 3; g++) begin : g_ctr
      if (g < NCTR) begin : g_live
         assign ctr_rise[g] = ctr_in[g] & ~ctr_q[g];
      end else begin : g_tied
         assign ctr_rise[g] = 1'b0;
      end
   end

   always_comb begin
      case (src)
         TRG_SOFT:     fire = sw_req;
         TRG_EXT_RISE: fire = ext_rise;
         TRG_EXT_FALL: fire = ext_fall;
         TRG_CTR0:     fire = ctr_rise[0];
         TRG_CTR1:     fire = ctr_rise[1];
         TRG_CTR2:     fire = ctr_rise[2];
         default:      fire = 1'b0;
      endcase
   end

endmodule

// File: rtl/dsf_scan.sv
module dsf_scan #(
   parameter int NCH = 16,
   parameter int CW  = 13,
   localparam int IW = $clog2(NCH),
   localparam int NW = $clog2(NCH + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           fire,
   input  logic           ena,
   input  logic [NCH-1:0] mask,
   input  logic [CW-1:0]  level,
   output logic           pop,
   output logic [IW-1:0]  wr_idx,
   output logic           busy
);

   logic [NCH-1:0] pend, low_bit;
   logic [NW-1:0]  need;
   logic           start;

   always_comb begin
      need = '0;
      for (int i = 0; i < NCH; i++) need = need + NW'(mask[i]);
   end

   always_comb begin
      wr_idx = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (pend[i]) wr_idx = IW'(i);
      end
   end

   assign low_bit = pend & (~pend + NCH'(1));
   assign busy    = |pend;
   assign pop     = busy;
   assign start   = fire & ena & ~busy & (|mask) & (level >= CW'(need));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pend <= '0;
      else if (clr)   pend <= '0;
      else if (start) pend <= mask;
      else if (busy)  pend <= pend & ~low_bit;
   end

endmodule

// File: rtl/dac_scan_fifo.sv
module dac_scan_fifo
   import dsf_pkg::*;
#(
   parameter int NCH      = 16,
   parameter int DAC_BITS = 12,
   parameter int DEPTH    = 4096,
   parameter int NCTR     = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_wr,
   input  logic                    bus_rd,
   input  logic [1:0]              bus_addr,
   input  logic [15:0]             bus_wdata,
   output logic [15:0]             bus_rdata,
   input  logic                    ext_trig,
   input  logic [NCTR-1:0]         ctr_tick,
   output logic                    irq,
   output logic                    polarity_bip,
   output logic [1:0]              vref_sel,
   output logic [NCH*DAC_BITS-1:0] dac_out
);

   localparam int WORD_W = 16;
   localparam int CW     = $clog2(DEPTH + 1);
   localparam int IW     = $clog2(NCH);
   localparam int HALF   = DEPTH / 2;

   if (NCH < 2 || NCH > 16) begin : g_bad_nch
      $error("dac_scan_fifo: NCH must lie in 2..16");
   end
   if (DAC_BITS < 1 || DAC_BITS > WORD_W) begin : g_bad_bits
      $error("dac_scan_fifo: DAC_BITS must lie in 1..16");
   end
   if (DEPTH < 2 * NCH || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("dac_scan_fifo: DEPTH must be a power of two of at least 2*NCH");
   end
   if (NCTR < 1 || NCTR > 3) begin : g_bad_nctr
      $error("dac_scan_fifo: NCTR must lie in 1..3");
   end

   cfg_t                cfg_q;
   logic [NCH-1:0]      mask_q;
   logic [DAC_BITS-1:0] dac_q [NCH];
   logic                wr_data, wr_ctrl, wr_mask, sw_req;
   logic                glob, fclr, clr;
   logic                fifo_en, wrap_en;
   logic                push, pop, pop_ok, busy, fire;
   logic [IW-1:0]       wr_idx;
   logic [WORD_W-1:0]   head;
   logic [CW-1:0]       level;
   logic [2:0]          fill_code;
   logic                is_empty, is_full, is_high;
   logic                unused_wbits;

   assign unused_wbits = ^bus_wdata[15:14];

   assign wr_data = bus_wr & (bus_addr == ADDR_DATA);
   assign wr_ctrl = bus_wr & (bus_addr == ADDR_CTRL);
   assign wr_mask = bus_wr & (bus_addr == ADDR_MASK);
   assign sw_req  = bus_rd & (bus_addr == ADDR_DATA);
   assign glob    = wr_ctrl & bus_wdata[BIT_ALL_CLR];
   assign fclr    = wr_ctrl & bus_wdata[BIT_FIFO_CLR] & ~bus_wdata[BIT_ALL_CLR];
   assign clr     = glob | fclr;

   assign fifo_en = cfg_q.fifo_en;
   assign wrap_en = cfg_q.wrap;

   // configuration register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (glob) begin
         cfg_q <= '0;
      end else if (wr_ctrl) begin
         cfg_q       <= cfg_t'(bus_wdata[11:0]);
         cfg_q.spare <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= '0;
      else if (glob)    mask_q <= '0;
      else if (wr_mask) mask_q <= bus_wdata[NCH-1:0];
   end

   assign push   = wr_data & fifo_en & ~busy;
   assign pop_ok = pop & ~clr;

   dsf_fifo #(.W(WORD_W), .DEPTH(DEPTH)) fifo_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .push      (push),
      .push_data (bus_wdata),
      .pop       (pop_ok),
      .recycle   (wrap_en),
      .head      (head),
      .level     (level)
   );

   dsf_trig #(.NCTR(NCTR)) trig_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .src    (cfg_q.trig),
      .sw_req (sw_req),
      .ext_in (ext_trig),
      .ctr_in (ctr_tick),
      .fire   (fire)
   );

   dsf_scan #(.NCH(NCH), .CW(CW)) scan_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .fire   (fire),
      .ena    (fifo_en),
      .mask   (mask_q),
      .level  (level),
      .pop    (pop),
      .wr_idx (wr_idx),
      .busy   (busy)
   );

   // channel output registers, loaded with the left-justified upper bits
   for (genvar c = 0; c < NCH; c++) begin : g_chan
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          dac_q[c] <= '0;
         else if (glob)                       dac_q[c] <= '0;
         else if (pop_ok && wr_idx == IW'(c)) dac_q[c] <= head[WORD_W-1 -: DAC_BITS];
      end
      assign dac_out[c*DAC_BITS +: DAC_BITS] = dac_q[c];
   end

   assign is_empty = (level == '0);
   assign is_full  = (level == CW'(DEPTH));
   assign is_high  = (level >= CW'(HALF));

   always_comb begin
      if (is_empty)     fill_code = FILL_EMPTY;
      else if (is_full) fill_code = FILL_FULL;
      else if (is_high) fill_code = FILL_HIGH;
      else              fill_code = FILL_LOW;
   end

   always_comb begin
      case (cfg_q.irq_sel)
         IRQ_EMPTY:     irq = is_empty;
         IRQ_NOT_EMPTY: irq = ~is_empty;
         IRQ_LOW_HALF:  irq = ~is_high;
         IRQ_HIGH_HALF: irq = is_high;
         IRQ_NOT_FULL:  irq = ~is_full;
         IRQ_FULL:      irq = is_full;
         default:       irq = 1'b0;
      endcase
      irq = irq & fifo_en;
   end

   always_comb begin
      case (bus_addr)
         ADDR_CTRL: bus_rdata = {busy, fill_code, 12'(cfg_q)};
         ADDR_MASK: bus_rdata = WORD_W'(mask_q);
         default:   bus_rdata = '0;
      endcase
   end

   assign polarity_bip = cfg_q.bipolar;
   assign vref_sel     = cfg_q.vref;

endmodule

// File: rtl/dac_scan_fifo_chk.sv
module dac_scan_fifo_chk #(
   parameter int NCH      = 16,
   parameter int DAC_BITS = 12,
   parameter int DEPTH    = 4096,
   localparam int CW      = $clog2(DEPTH + 1)
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    busy,
   input logic                    pop,
   input logic [CW-1:0]           level,
   input logic [2:0]              fill,
   input logic                    irq,
   input logic                    fifo_en,
   input logic                    wrap_en,
   input logic                    clr,
   input logic                    glob,
   input logic                    fire,
   input logic [NCH-1:0]          mask,
   input logic [NCH*DAC_BITS-1:0] dac_out
);

   // R3
   fill_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fill == 3'd0 || fill == 3'd1 || fill == 3'd4 || fill == 3'd6));

   // R3
   level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      level <= CW'(DEPTH));

   // R7
   pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> level != '0);

   // R7
   dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !glob) |=> $stable(dac_out));

   // R8
   short_trigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !busy && fifo_en && (int'(level) < $countones(mask))) |=> !busy);

   // R9
   wrap_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wrap_en && !clr) |=> level == $past(level));

   // R4
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_en |-> !irq);

   // R10
   clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (level == '0 && !busy));

endmodule

bind dac_scan_fifo dac_scan_fifo_chk #(
   .NCH(NCH), .DAC_BITS(DAC_BITS), .DEPTH(DEPTH)
) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .busy    (busy),
   .pop     (pop_ok),
   .level   (level),
   .fill    (fill_code),
   .irq     (irq),
   .fifo_en (fifo_en),
   .wrap_en (wrap_en),
   .clr     (clr),
   .glob    (glob),
   .fire    (fire),
   .mask    (mask_q),
   .dac_out (dac_out)
);

// File: tb/dac_scan_fifo_tb_top.sv
`timescale 1ns/1ps
module dac_scan_fifo_tb_top;

   localparam int NCH      = 16;
   localparam int DAC_BITS = 12;
   localparam int DEPTH    = 4096;
   localparam int NCTR     = 3;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    bus_wr = 1'b0, bus_rd = 1'b0;
   logic [1:0]              bus_addr = 2'd0;
   logic [15:0]             bus_wdata = 16'd0;
   logic [15:0]             bus_rdata;
   logic                    ext_trig = 1'b0;
   logic [NCTR-1:0]         ctr_tick = '0;
   logic                    irq, polarity_bip;
   logic [1:0]              vref_sel;
   logic [NCH*DAC_BITS-1:0] dac_out;

   always #2 clk = ~clk;

   dac_scan_fifo #(.NCH(NCH), .DAC_BITS(DAC_BITS), .DEPTH(DEPTH), .NCTR(NCTR)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_trig(ext_trig), .ctr_tick(ctr_tick),
      .irq(irq), .polarity_bip(polarity_bip), .vref_sel(vref_sel), .dac_out(dac_out)
   );

   // reference model
   logic [15:0]         mq[$];
   logic [11:0]         m_ctl = '0;
   logic [15:0]         m_mask = '0;
   logic [DAC_BITS-1:0] m_dac [NCH];
   int n_cmp = 0, n_bad = 0;

   function automatic logic [2:0] exp_fill(int sz);
      if (sz == 0) return 3'd1;
      if (sz == DEPTH) return 3'd6;
      if (sz >= DEPTH / 2) return 3'd4;
      return 3'd0;
   endfunction

   function automatic logic exp_irq(int sz);
      logic r;
      case (m_ctl[11:9])
         3'd0: r = (sz == 0);
         3'd1: r = (sz != 0);
         3'd2: r = (sz < DEPTH / 2);
         3'd3: r = (sz >= DEPTH / 2);
         3'd4: r = (sz < DEPTH);
         3'd5: r = (sz == DEPTH);
         default: r = 1'b0;
      endcase
      return r & m_ctl[8];
   endfunction

   function automatic logic [NCH*DAC_BITS-1:0] exp_dac();
      logic [NCH*DAC_BITS-1:0] e;
      for (int c = 0; c < NCH; c++) e[c*DAC_BITS +: DAC_BITS] = m_dac[c];
      return e;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chk_dac(input string tag);
      n_cmp++;
      if (dac_out !== exp_dac()) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, dac_out, exp_dac());
      end
   endtask

   // all bus tasks start and end at a falling edge
   task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [15:0] v);
      bus_rd = 1'b1; bus_addr = a;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic model_reset();
      mq.delete(); m_ctl = '0; m_mask = '0;
      for (int c = 0; c < NCH; c++) m_dac[c] = '0;
   endtask

   task automatic push_word(input logic [15:0] w);
      bus_write(2'd0, w);
      if (m_ctl[8] && mq.size() < DEPTH) mq.push_back(w);
   endtask

   task automatic set_ctl(input logic [15:0] v);
      bus_write(2'd1, v);
      if (v[13]) model_reset();
      else begin
         if (v[12]) mq.delete();
         m_ctl = v[11:0] & 12'hFBF;
      end
   endtask

   task automatic set_mask(input logic [15:0] v);
      bus_write(2'd2, v);
      m_mask = v;
   endtask

   task automatic model_scan();
      logic [15:0] w;
      if (m_ctl[8] && m_mask != 0 && mq.size() >= $countones(m_mask)) begin
         for (int c = 0; c < NCH; c++) begin
            if (m_mask[c]) begin
               w = mq.pop_front();
               m_dac[c] = w[15 -: DAC_BITS];
               if (m_ctl[7]) mq.push_back(w);
            end
         end
      end
   endtask

   // stimulus for the configured source, then wait for the scan to end
   task automatic fire_src();
      logic [15:0] v;
      case (m_ctl[2:0])
         3'd1: bus_read(2'd0, v);
         3'd2, 3'd3: begin
            ext_trig = 1'b1; @(negedge clk);
            ext_trig = 1'b0; @(negedge clk);
         end
         3'd4, 3'd5, 3'd6: begin
            ctr_tick[m_ctl[2:0] - 3'd4] = 1'b1; @(negedge clk);
            ctr_tick = '0; @(negedge clk);
         end
         default: begin
            bus_read(2'd0, v);
            ext_trig = 1'b1; @(negedge clk);
            ext_trig = 1'b0; @(negedge clk);
         end
      endcase
      if (m_ctl[2:0] >= 3'd1 && m_ctl[2:0] <= 3'd6) model_scan();
      idle(20);
   endtask

   task automatic check_all(input string tag);
      logic [15:0] v;
      bus_read(2'd1, v);
      chk({tag, " status"}, v, {1'b0, exp_fill(mq.size()), m_ctl});
      chk({tag, " irq"}, irq, exp_irq(mq.size()));
      chk({tag, " analog R2"}, {polarity_bip, vref_sel}, {m_ctl[3], m_ctl[5:4]});
      bus_read(2'd2, v);
      chk({tag, " mask R12"}, v, m_mask);
      chk_dac({tag, " dac"});
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_bad++;
      $display("FAIL R7 watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [15:0] v;
      void'($urandom(32'd20240611));
      model_reset();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      bus_read(2'd1, v); chk("R1 status", v, 16'h1000);
      chk("R1 irq", irq, 1'b0);
      check_all("R1");
      bus_read(2'd0, v); chk("R12 data read", v, 16'h0000);

      // R2 field storage, spare bit reads zero; R4 spare condition never fires
      set_ctl(16'h0FFF); check_all("R2 R4");

      // R5 disabled FIFO drops data
      set_ctl(16'h0000); push_word(16'h1234); check_all("R5 disabled");

      // R4 not-empty condition, R8 too few words
      set_ctl(16'h0301);
      set_mask(16'h000F);
      push_word(16'hA000); push_word(16'hB110); push_word(16'hC220);
      check_all("R4 not-empty");
      fire_src(); check_all("R8 short");

      // R7 scan order and busy
      push_word(16'hD330);
      bus_read(2'd0, v);
      bus_read(2'd1, v); chk("R7 busy", v[15], 1'b1);
      model_scan();
      idle(20);
      bus_read(2'd1, v); chk("R7 idle", v[15], 1'b0);
      check_all("R7 scan");

      // R8 trigger while busy is ignored
      set_mask(16'hFFFF);
      for (int i = 0; i < 32; i++) push_word(16'(i * 16'h0531));
      bus_read(2'd0, v); bus_read(2'd0, v);
      model_scan(); idle(20);
      check_all("R8 busy");
      set_ctl(16'h1301);

      // R6 falling edge: the rise alone must not fire
      set_ctl(16'h0303); set_mask(16'h8001);
      push_word(16'h7FF0); push_word(16'h0123);
      ext_trig = 1'b1; idle(3); check_all("R6 rise ignored");
      ext_trig = 1'b0; idle(1); model_scan(); idle(20); check_all("R6 fall");

      // R6 counter 2 select: counter 0 ignored
      set_ctl(16'h0306);
      push_word(16'h4560); push_word(16'h89A0);
      ctr_tick = 3'b001; idle(1); ctr_tick = '0; idle(3); check_all("R6 ctr0 ignored");
      ctr_tick = 3'b100; idle(1); ctr_tick = '0; idle(1); model_scan(); idle(20);
      check_all("R6 ctr2");

      // R9 wrap keeps the level and repeats
      set_ctl(16'h1381); set_mask(16'h0003);
      push_word(16'h1110); push_word(16'h2220); push_word(16'h3330);
      for (int k = 0; k < 4; k++) begin fire_src(); check_all("R9 wrap"); end

      // R10 FIFO reset keeps the written fields
      set_ctl(16'h1325); check_all("R10");

      // R3 fill boundaries, R5 full drop
      set_ctl(16'h1701);
      for (int i = 0; i < DEPTH / 2 - 1; i++) push_word(16'(i));
      check_all("R3 below half");
      push_word(16'hFFF0); check_all("R3 half");
      for (int i = 0; i < DEPTH / 2 - 1; i++) push_word(16'(i ^ 16'h5A5A));
      check_all("R3 near full");
      push_word(16'hEEE0); set_ctl(16'h0B01); check_all("R3 full");
      push_word(16'hDDD0); check_all("R5 full drop");
      set_mask(16'hFFFF); fire_src(); check_all("R7 full scan");

      // R11 global reset
      set_ctl(16'h2FFF); check_all("R11");

      // random phase
      for (int it = 0; it < 400; it++) begin
         case ($urandom_range(0, 5))
            0: for (int k = $urandom_range(1, 24); k > 0; k--) push_word(16'($urandom()));
            1: set_mask(($urandom_range(0, 3) == 0) ? 16'(1 << $urandom_range(0, 15))
                                                     : 16'($urandom()));
            2: set_ctl({3'b000, ($urandom_range(0, 9) == 0), $urandom_range(0, 7) == 0 ? 3'd7 : 3'($urandom_range(0, 5)),
                        ($urandom_range(0, 5) != 0), 1'($urandom_range(0, 1)), 1'b0,
                        2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 3'($urandom_range(0, 7))});
            5: begin bus_read(2'd0, v); if (m_ctl[2:0] == 3'd1) model_scan(); idle(20); end
            default: fire_src();
         endcase
         check_all("R6 R7 R9 random");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule